// File: doc/BRIEF.md
# Widening Integer Add/Subtract Decoder with Legality Check

This block sits in the issue path of a vector unit. It receives a 32-bit instruction word together with the current element-width code and register-grouping code. It picks out the widening integer add and subtract operations: unsigned or signed, add or subtract, each in vector-vector and vector-scalar form. Each operation also exists in a variant whose vector operand at bits [24:20] already holds double-width elements. For a recognised word the block reports the operation attributes, the register indices and an illegal-instruction flag.

The illegal flag combines several rules. Result widths are limited. Register groups must be aligned. The double-length destination group must not overlap any narrow vector source group. A masked operation must not write into register 0. Words outside this family are reported as not recognised, so that a neighbouring decoder can claim them. The decision is registered once: results appear one clock after the word is presented with `in_valid`.

Top module: `widen_addsub_decoder`

## Requirements
- R1: A word is recognised only when bits [6:0] are 1010111, bits [31:29] are 110 and bits [14:12] are 010 or 110. For any other word, out_match, out_illegal and every attribute and index output are 0.
- R2: For a recognised word, bit 27 set means subtract (else add), bit 26 set means signed (else unsigned), bit 28 set means the bits [24:20] operand is wide, and bit 14 set means the bits [19:15] operand is a scalar register.
- R3: out_masked is the inverse of bit 25. out_rd is bits [11:7], out_rs_b is bits [19:15] and out_rs_a is bits [24:20].
- R4: A recognised word is illegal when the element-width code is 3 or the grouping code is 3.
- R5: With grouping code L, the destination index must be a multiple of 2<<L, and so must the bits [24:20] index when that operand is wide. Otherwise the word is illegal.
- R6: Every narrow vector source index must be a multiple of 1<<L, or the word is illegal.
- R7: For every narrow vector source rs, the word is legal only if rd >= rs + (1<<L) or rs >= rd + (2<<L).
- R8: No overlap test is applied to a wide operand. No alignment or overlap test is applied to the scalar index.
- R9: A masked word (bit 25 = 0) with destination index 0 is illegal.
- R10: All outputs are registered. They reflect the word presented on the previous clock edge while in_valid was 1, and are all 0 after reset or after a cycle without in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| sew_i | input | 2 | Element-width code |
| lmul_i | input | 2 | Register-grouping code |
| out_valid | output | 1 | Decode result valid |
| out_match | output | 1 | Word belongs to the widening add/subtract family |
| out_illegal | output | 1 | Recognised word violates a legality rule |
| out_sub | output | 1 | Subtract operation |
| out_signed | output | 1 | Signed operands |
| out_wide_a | output | 1 | Bits [24:20] operand is already wide |
| out_scalar_b | output | 1 | Bits [19:15] operand is a scalar register |
| out_masked | output | 1 | Operation is masked |
| out_rd | output | 5 | Destination index |
| out_rs_a | output | 5 | Index from bits [24:20] |
| out_rs_b | output | 5 | Index from bits [19:15] |

## Verification
A bad internal decision shows up on the port outputs exactly one clock after the offending word, because the block has a single register stage and no other state. A swapped alignment length, an overlap test on the wrong operand or a wrong boundary comparison appears as a flipped out_illegal on some register pattern. A corrupted decode field appears as a wrong attribute or index. The directed cases place source groups at distance zero and exactly at the group edges. Random words with often-aligned indices cover the rest of the index space, for every element-width and grouping code.

// File: rtl/widen_dec_pkg.sv
package widen_dec_pkg;

    parameter int REG_W   = 5;
    parameter int INSTR_W = 32;
    parameter int CODE_W  = 2;
    parameter int GRP_W   = REG_W + 1;

    localparam logic [6:0]    VEC_OPC      = 7'b1010111;
    localparam logic [2:0]    FAMILY_TOP   = 3'b110;
    localparam logic [2:0]    FORM_VV      = 3'b010;
    localparam logic [2:0]    FORM_VX      = 3'b110;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    typedef struct packed {
        logic             valid;
        logic             match;
        logic             illegal;
        logic             sub;
        logic             sgn;
        logic             wide_a;
        logic             scalar_b;
        logic             masked;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs_a;
        logic [REG_W-1:0] rs_b;
    } wdec_res_t;

endpackage

// File: rtl/widen_field_decode.sv
module widen_field_decode
    import widen_dec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               recognised,
    output logic               is_sub,
    output logic               is_signed,
    output logic               wide_a,
    output logic               scalar_b,
    output logic               masked,
    output logic [REG_W-1:0]   rd,
    output logic [REG_W-1:0]   rs_a,
    output logic [REG_W-1:0]   rs_b
);
    logic [2:0] form;

    always_comb begin
        form       = instr[14:12];
        recognised = (instr[6:0] == VEC_OPC) &&
                     (instr[31:29] == FAMILY_TOP) &&
                     ((form == FORM_VV) || (form == FORM_VX));
        is_signed  = instr[26];
        is_sub     = instr[27];
        wide_a     = instr[28];
        scalar_b   = instr[14];
        masked     = ~instr[25];
        rd         = instr[11:7];
        rs_b       = instr[19:15];
        rs_a       = instr[24:20];
    end

endmodule

// File: rtl/widen_src_check.sv
module widen_src_check
    import widen_dec_pkg::*;
(
    input  logic              en,
    input  logic              dbl_align,
    input  logic              chk_ovl,
    input  logic [REG_W-1:0]  rd,
    input  logic [REG_W-1:0]  rs,
    input  logic [CODE_W-1:0] lmul,
    output logic              bad
);
    logic [GRP_W-1:0] slen;
    logic [GRP_W-1:0] dlen;
    logic [GRP_W-1:0] alen;
    logic [GRP_W-1:0] rd_x;
    logic [GRP_W-1:0] rs_x;
    logic             misalign;
    logic             overlap;

    always_comb begin
        slen     = GRP_W'(1) << lmul;
        dlen     = slen << 1;
        alen     = dbl_align ? dlen : slen;
        rd_x     = {1'b0, rd};
        rs_x     = {1'b0, rs};
        misalign = (rs_x & (alen - GRP_W'(1))) != '0;
        overlap  = chk_ovl && !((rd_x >= rs_x + slen) || (rs_x >= rd_x + dlen));
        bad      = en && (misalign || overlap);
    end

endmodule

// File: rtl/widen_addsub_decoder.sv
module widen_addsub_decoder
    import widen_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [CODE_W-1:0]  sew_i,
    input  logic [CODE_W-1:0]  lmul_i,
    output logic               out_valid,
    output logic               out_match,
    output logic               out_illegal,
    output logic               out_sub,
    output logic               out_signed,
    output logic               out_wide_a,
    output logic               out_scalar_b,
    output logic               out_masked,
    output logic [REG_W-1:0]   out_rd,
    output logic [REG_W-1:0]   out_rs_a,
    output logic [REG_W-1:0]   out_rs_b
);
    localparam int N_CHK = 3;

    logic             f_rec, f_sub, f_sgn, f_wide, f_scal, f_msk;
    logic [REG_W-1:0] f_rd, f_ra, f_rb;

    logic             chk_en   [N_CHK];
    logic             chk_dbl  [N_CHK];
    logic             chk_ovl  [N_CHK];
    logic [REG_W-1:0] chk_idx  [N_CHK];
    logic             chk_bad  [N_CHK];

    logic             width_bad;
    logic             mask_bad;
    logic             any_bad;

    wdec_res_t dec_d, dec_q;

    widen_field_decode u_fields (
        .instr      (instr_i),
        .recognised (f_rec),
        .is_sub     (f_sub),
        .is_signed  (f_sgn),
        .wide_a     (f_wide),
        .scalar_b   (f_scal),
        .masked     (f_msk),
        .rd         (f_rd),
        .rs_a       (f_ra),
        .rs_b       (f_rb)
    );

    // slot 0: destination, slot 1: operand at [24:20], slot 2: operand at [19:15]
    always_comb begin
        chk_en[0]  = 1'b1;
        chk_dbl[0] = 1'b1;
        chk_ovl[0] = 1'b0;
        chk_idx[0] = f_rd;
        chk_en[1]  = 1'b1;
        chk_dbl[1] = f_wide;
        chk_ovl[1] = ~f_wide;
        chk_idx[1] = f_ra;
        chk_en[2]  = ~f_scal;
        chk_dbl[2] = 1'b0;
        chk_ovl[2] = 1'b1;
        chk_idx[2] = f_rb;
    end

    for (genvar g = 0; g < N_CHK; g++) begin : g_chk
        widen_src_check u_chk (
            .en        (chk_en[g]),
            .dbl_align (chk_dbl[g]),
            .chk_ovl   (chk_ovl[g]),
            .rd        (f_rd),
            .rs        (chk_idx[g]),
            .lmul      (lmul_i),
            .bad       (chk_bad[g])
        );
    end

    always_comb begin
        width_bad = (sew_i == CODE_MAX) || (lmul_i == CODE_MAX);
        mask_bad  = f_msk && (f_rd == '0);
        any_bad   = width_bad || mask_bad;
        for (int i = 0; i < N_CHK; i++) begin
            any_bad = any_bad || chk_bad[i];
        end

        dec_d = '0;
        if (in_valid) begin
            dec_d.valid = 1'b1;
            if (f_rec) begin
                dec_d.match    = 1'b1;
                dec_d.illegal  = any_bad;
                dec_d.sub      = f_sub;
                dec_d.sgn      = f_sgn;
                dec_d.wide_a   = f_wide;
                dec_d.scalar_b = f_scal;
                dec_d.masked   = f_msk;
                dec_d.rd       = f_rd;
                dec_d.rs_a     = f_ra;
                dec_d.rs_b     = f_rb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign out_valid    = dec_q.valid;
    assign out_match    = dec_q.match;
    assign out_illegal  = dec_q.illegal;
    assign out_sub      = dec_q.sub;
    assign out_signed   = dec_q.sgn;
    assign out_wide_a   = dec_q.wide_a;
    assign out_scalar_b = dec_q.scalar_b;
    assign out_masked   = dec_q.masked;
    assign out_rd       = dec_q.rd;
    assign out_rs_a     = dec_q.rs_a;
    assign out_rs_b     = dec_q.rs_b;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_match); // R10
    AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_match |-> !out_illegal && out_rd == '0 && !out_masked); // R1
    AST_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (sew_i == CODE_MAX || lmul_i == CODE_MAX) |=> !out_match || out_illegal); // R4
    AST_RD_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        out_match && out_rd[0] |-> out_illegal); // R5
    AST_MASK_V0: assert property (@(posedge clk) disable iff (!rst_n)
        out_match && out_masked && out_rd == '0 |-> out_illegal); // R9

endmodule

// File: tb/test_widen_addsub_decoder.sv
module test_widen_addsub_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr_i = '0;
    logic [1:0]  sew_i = '0;
    logic [1:0]  lmul_i = '0;
    logic        out_valid, out_match, out_illegal, out_sub, out_signed;
    logic        out_wide_a, out_scalar_b, out_masked;
    logic [4:0]  out_rd, out_rs_a, out_rs_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    widen_addsub_decoder i_widen_addsub_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr_i(instr_i),
        .sew_i(sew_i), .lmul_i(lmul_i), .out_valid(out_valid),
        .out_match(out_match), .out_illegal(out_illegal), .out_sub(out_sub),
        .out_signed(out_signed), .out_wide_a(out_wide_a),
        .out_scalar_b(out_scalar_b), .out_masked(out_masked),
        .out_rd(out_rd), .out_rs_a(out_rs_a), .out_rs_b(out_rs_b)
    );

    function automatic logic [31:0] mk(logic [5:0] f6, logic vm, logic [4:0] ra,
                                       logic [4:0] rb, logic [2:0] f3, logic [4:0] rd);
        return {f6, vm, ra, rb, f3, rd, 7'b1010111};
    endfunction

    function automatic bit grp_bad(int rd, int rs, int s, int d);
        return !((rd >= rs + s) || (rs >= rd + d));
    endfunction

    // {match, illegal, sub, signed, wide, scalar, masked, rd, rs_a, rs_b}
    function automatic logic [21:0] ref_model(logic [31:0] w, logic [1:0] sew, logic [1:0] lm);
        int rd, ra, rb, s, d;
        bit ill, wide, scal, msk;
        if (!(w[6:0] == 7'b1010111 && w[31:29] == 3'b110 &&
              (w[14:12] == 3'b010 || w[14:12] == 3'b110)))
            return '0;
        rd = int'(w[11:7]); ra = int'(w[24:20]); rb = int'(w[19:15]);
        wide = w[28]; scal = w[14]; msk = !w[25];
        ill = (sew == 2'd3) || (lm == 2'd3);
        s = 1 << lm; d = 2 << lm;
        if (rd % d != 0) ill = 1;
        if (wide) begin
            if (ra % d != 0) ill = 1;
        end else begin
            if (ra % s != 0 || grp_bad(rd, ra, s, d)) ill = 1;
        end
        if (!scal && (rb % s != 0 || grp_bad(rd, rb, s, d))) ill = 1;
        if (msk && rd == 0) ill = 1;
        return {1'b1, ill, w[27], w[26], wide, scal, msk, w[11:7], w[24:20], w[19:15]};
    endfunction

    function automatic logic [21:0] actual();
        return {out_match, out_illegal, out_sub, out_signed, out_wide_a, out_scalar_b,
                out_masked, out_rd, out_rs_a, out_rs_b};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(logic v, logic [31:0] w, logic [1:0] sew, logic [1:0] lm);
        @(negedge clk);
        in_valid = v; instr_i = w; sew_i = sew; lmul_i = lm;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic full_check(logic [31:0] w, logic [1:0] sew, logic [1:0] lm);
        logic [21:0] e;
        e = ref_model(w, sew, lm);
        check("R1 match", 32'(out_match), 32'(e[21]));
        check("R2 op fields", 32'({out_sub, out_signed, out_wide_a, out_scalar_b}), 32'(e[19:16]));
        check("R3 mask/indices", 32'({out_masked, out_rd, out_rs_a, out_rs_b}), 32'(e[15:0]));
        check("R4/R5/R6/R7/R8/R9 illegal", 32'(out_illegal), 32'(e[20]));
        check("R10 valid", 32'(out_valid), 32'd1);
    endtask

    task automatic directed(string tag, logic [31:0] w, logic [1:0] sew, logic [1:0] lm,
                            logic em, logic ei);
        apply(1'b1, w, sew, lm);
        check({tag, " match"}, 32'(out_match), 32'(em));
        check({tag, " illegal"}, 32'(out_illegal), 32'(ei));
        full_check(w, sew, lm);
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        check("R10 reset valid", 32'(out_valid), 32'd0);
        check("R10 reset match", 32'(out_match), 32'd0);
        rst_n = 1'b1;

        // legal signed vv add, lmul 0
        directed("R2 signed add vv", mk(6'b110001, 1'b1, 5'd4, 5'd6, 3'b010, 5'd2), 2'd0, 2'd0, 1, 0);
        // R7: narrow source inside destination group
        directed("R7 overlap", mk(6'b110000, 1'b1, 5'd8, 5'd6, 3'b010, 5'd4), 2'd1, 2'd1, 1, 1);
        // R7: boundaries exactly at the edges
        directed("R7 edge below", mk(6'b110000, 1'b1, 5'd8, 5'd2, 3'b010, 5'd4), 2'd1, 2'd1, 1, 0);
        directed("R7 edge above", mk(6'b110010, 1'b1, 5'd8, 5'd10, 3'b010, 5'd4), 2'd1, 2'd1, 1, 0);
        // R8: wide operand equals destination, no overlap test
        directed("R8 wide same", mk(6'b110100, 1'b1, 5'd4, 5'd8, 3'b010, 5'd4), 2'd1, 2'd1, 1, 0);
        // R5: wide operand alignment to double group
        directed("R5 wide misalign", mk(6'b110101, 1'b1, 5'd2, 5'd8, 3'b010, 5'd4), 2'd1, 2'd1, 1, 1);
        // R8: scalar index unaligned and inside group
        directed("R8 scalar", mk(6'b110011, 1'b1, 5'd8, 5'd5, 3'b110, 5'd4), 2'd1, 2'd1, 1, 0);
        // R4: width limits
        directed("R4 sew3", mk(6'b110001, 1'b1, 5'd4, 5'd6, 3'b010, 5'd2), 2'd3, 2'd0, 1, 1);
        directed("R4 lmul3", mk(6'b110001, 1'b1, 5'd16, 5'd24, 3'b010, 5'd0), 2'd0, 2'd3, 1, 1);
        // R9: masked write to register 0
        directed("R9 masked v0", mk(6'b110000, 1'b0, 5'd4, 5'd6, 3'b010, 5'd0), 2'd0, 2'd0, 1, 1);
        directed("R9 masked v2", mk(6'b110000, 1'b0, 5'd4, 5'd6, 3'b010, 5'd2), 2'd0, 2'd0, 1, 0);
        // R5: destination misaligned; R6: narrow source misaligned
        directed("R5 rd misalign", mk(6'b110000, 1'b1, 5'd8, 5'd10, 3'b010, 5'd2), 2'd1, 2'd1, 1, 1);
        directed("R6 rs misalign", mk(6'b110000, 1'b1, 5'd9, 5'd10, 3'b010, 5'd4), 2'd1, 2'd1, 1, 1);
        // R1: other form and other opcode not recognised
        directed("R1 funct3", mk(6'b110000, 1'b1, 5'd4, 5'd6, 3'b000, 5'd2), 2'd0, 2'd0, 0, 0);
        directed("R1 funct6", mk(6'b100000, 1'b1, 5'd4, 5'd6, 3'b010, 5'd2), 2'd0, 2'd0, 0, 0);
        // R10: idle cycle clears outputs
        apply(1'b0, mk(6'b110001, 1'b1, 5'd4, 5'd6, 3'b010, 5'd2), 2'd0, 2'd0);
        check("R10 idle valid", 32'(out_valid), 32'd0);
        check("R10 idle match", 32'(out_match), 32'd0);

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            logic [2:0]  f3sel;
            w = $urandom;
            if ($urandom_range(0, 9) != 0) w[6:0] = 7'b1010111;
            if ($urandom_range(0, 9) != 0) w[31:29] = 3'b110;
            f3sel = 3'($urandom_range(0, 4));
            if (f3sel < 2) w[14:12] = 3'b010;
            else if (f3sel < 4) w[14:12] = 3'b110;
            if ($urandom_range(0, 1) == 1) begin
                w[9:7] = '0; w[22:20] = '0; w[17:15] = '0;
            end
            apply(1'b1, w, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
            full_check(w, sew_i, lmul_i);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule